// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Controller

This block owns two sample RAMs and sits between a packet receiver and a paced reader that feeds a converter. Incoming samples go into one RAM while the reader drains the other. At every swap the roles exchange, so filling and draining overlap and the converter never sees a gap while data keeps arriving in time. One instance serves one channel.

Start-up is primed in two phases. The first packet lands in buffer 0 and reception stays open. The second packet lands in buffer 1. When the second packet completes, the reader is pointed at buffer 0 and the pacing timer is enabled. From then on, buffers change roles only when the reader reports that a transfer is complete. Each swap loads the new read source and its sample count, and it re-opens reception for the buffer that was just drained.

If the reader finishes before the next packet is complete, the controller stalls. It raises an underrun indication, stops the pacing timer and keeps the last output sample. The swap then happens as soon as that packet completes.

Top module: `pingpong_ctrl`

## Requirements
- R1: After reset: `wr_buf`=0, `src_sel`=0, `rx_allow`=1, `tmr_en`=0, `xfer_cnt`=0, `underrun`=0 and `overflow`=0.
- R2: Samples of the first packet are written to buffer 0 (`wr_buf`=0 selects buffer 0, 1 selects buffer 1). When that packet ends, `wr_buf` becomes 1, `rx_allow` stays 1 and `tmr_en` stays 0.
- R3: When the second packet ends, the following hold one cycle later: `wr_buf`=0, `src_sel`=0, `xfer_cnt` equal to the length of the first packet, `tmr_en`=1 and `rx_allow`=0.
- R4: A `xfer_done` pulse while the other buffer holds a completed packet swaps the buffers one cycle later. `src_sel` toggles, `xfer_cnt` becomes that packet's length, `wr_buf` takes the drained buffer and `rx_allow` becomes 1.
- R5: A packet that ends while draining is running sets `rx_allow` to 0. It leaves `src_sel`, `xfer_cnt` and `tmr_en` unchanged.
- R6: A `xfer_done` pulse while the other buffer is not complete sets `underrun`=1 and `tmr_en`=0, and `smp_out` holds its last value. The next packet end then swaps at once: `underrun`=0, `tmr_en`=1, `src_sel` and `wr_buf` exchange, `xfer_cnt` takes the new length and `rx_allow` stays 1.
- R7: A write with `rx_allow`=0 is not stored, and it sets `overflow`. `overflow` stays set until reset.
- R8: A cycle with `rd_en` high loads `smp_out` with word `rd_addr` of the buffer selected by `src_sel`, one cycle later. Otherwise `smp_out` holds its value.
- R9: A `pkt_done` pulse with `rx_allow`=0 has no effect.
- R10: A sample written in the same cycle as `pkt_done` counts in that packet's length. A packet keeps at most DEPTH samples. Writes beyond that are dropped and set `overflow`, and the length reported is DEPTH.
- R11: A `xfer_done` pulse before priming completes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Incoming sample valid |
| wr_data | input | DW | Incoming sample |
| pkt_done | input | 1 | Last-sample-of-packet strobe |
| xfer_done | input | 1 | Reader finished the current transfer |
| rd_en | input | 1 | Reader fetch request |
| rd_addr | input | log2(DEPTH) | Reader word address |
| wr_buf | output | 1 | Buffer currently receiving |
| src_sel | output | 1 | Buffer the reader drains |
| xfer_cnt | output | log2(DEPTH+1) | Samples to drain from `src_sel` |
| rx_allow | output | 1 | Receiver may deliver the next packet |
| tmr_en | output | 1 | Pacing timer enable |
| underrun | output | 1 | Reader starved, waiting for a packet |
| overflow | output | 1 | Sticky: a sample was dropped |
| smp_out | output | DW | Sample fetched for the converter |

## Verification
The properties assume that `pkt_done` and `xfer_done` are single-cycle pulses. They also assume that the reader raises `xfer_done` only while `tmr_en` is high, after fetching the count it was given. The stimulus follows this: every transfer-complete pulse comes only after the bench has read the words of the active buffer, except the deliberate pulse during priming. Packets never carry zero samples, and `rd_en` is used only while the pacing timer runs, apart from the stall case where hold is checked.

// File: rtl/pingpong_ctrl.sv
module pingpong_ctrl #(
  parameter int DW = 12,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          pkt_done,
  input  logic          xfer_done,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          wr_buf,
  output logic          src_sel,
  output logic [CW-1:0] xfer_cnt,
  output logic          rx_allow,
  output logic          tmr_en,
  output logic          underrun,
  output logic          overflow,
  output logic [DW-1:0] smp_out
);

  typedef enum logic [1:0] {PRIME1, PRIME2, RUN, STALL} st_t;

  st_t           st;
  logic [DW-1:0] ram0 [DEPTH];
  logic [DW-1:0] ram1 [DEPTH];
  logic [CW-1:0] fill, fill_nx, cnt_hold;
  logic          ready;

  wire take = wr_valid && rx_allow && (fill < CW'(DEPTH));
  wire fin  = pkt_done && rx_allow;

  assign fill_nx  = fill + CW'(take);
  assign underrun = (st == STALL);

  always_ff @(posedge clk) begin
    if (take) begin
      if (wr_buf) ram1[fill[AW-1:0]] <= wr_data;
      else        ram0[fill[AW-1:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     smp_out <= '0;
    else if (rd_en) smp_out <= src_sel ? ram1[rd_addr] : ram0[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PRIME1;
      wr_buf   <= 1'b0;
      src_sel  <= 1'b0;
      xfer_cnt <= '0;
      cnt_hold <= '0;
      rx_allow <= 1'b1;
      tmr_en   <= 1'b0;
      ready    <= 1'b0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_valid && !take) overflow <= 1'b1;
      fill <= fin ? '0 : fill_nx;
      case (st)
        PRIME1: if (fin) begin
          cnt_hold <= fill_nx;
          wr_buf   <= 1'b1;
          st       <= PRIME2;
        end
        PRIME2: if (fin) begin
          xfer_cnt <= cnt_hold;
          cnt_hold <= fill_nx;
          ready    <= 1'b1;
          wr_buf   <= 1'b0;
          src_sel  <= 1'b0;
          tmr_en   <= 1'b1;
          rx_allow <= 1'b0;
          st       <= RUN;
        end
        RUN: if (xfer_done) begin
          if (ready || fin) begin
            src_sel  <= ~src_sel;
            xfer_cnt <= ready ? cnt_hold : fill_nx;
            wr_buf   <= src_sel;
            rx_allow <= 1'b1;
            ready    <= 1'b0;
          end else begin
            tmr_en <= 1'b0;
            st     <= STALL;
          end
        end else if (fin) begin
          cnt_hold <= fill_nx;
          ready    <= 1'b1;
          rx_allow <= 1'b0;
        end
        STALL: if (fin) begin
          src_sel  <= wr_buf;
          wr_buf   <= src_sel;
          xfer_cnt <= fill_nx;
          tmr_en   <= 1'b1;
          st       <= RUN;
        end
        default: st <= PRIME1;
      endcase
    end
  end

endmodule

// File: rtl/pingpong_ctrl_chk.sv
module pingpong_ctrl_chk #(
  parameter int DW = 12,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          pkt_done,
  input logic          xfer_done,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_buf,
  input logic          src_sel,
  input logic [CW-1:0] xfer_cnt,
  input logic          rx_allow,
  input logic          tmr_en,
  input logic          underrun,
  input logic          overflow,
  input logic [DW-1:0] smp_out
);

  // R6
  stall_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !tmr_en);

  // R4
  swap_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sel) |-> (rx_allow && tmr_en));

  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !rx_allow) |=> overflow);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(smp_out));

  // R9
  ignore_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !rx_allow && !xfer_done) |=>
      ($stable(wr_buf) && $stable(xfer_cnt) && $stable(src_sel)));

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_cnt <= CW'(DEPTH));

endmodule

bind pingpong_ctrl pingpong_ctrl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .pkt_done(pkt_done),
  .xfer_done(xfer_done), .rd_en(rd_en), .rd_addr(rd_addr), .wr_buf(wr_buf),
  .src_sel(src_sel), .xfer_cnt(xfer_cnt), .rx_allow(rx_allow),
  .tmr_en(tmr_en), .underrun(underrun), .overflow(overflow),
  .smp_out(smp_out)
);

// File: tb/test_pingpong_ctrl.sv
module test_pingpong_ctrl;
  localparam int CLK_NS = 10;
  localparam int DW = 12;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, pkt_done = 0, xfer_done = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_buf, src_sel, rx_allow, tmr_en, underrun, overflow;
  logic [CW-1:0] xfer_cnt;
  logic [DW-1:0] smp_out;

  int vectors = 0, miscompares = 0;
  bit done = 0, pend = 0;
  int exp_q[$];

  pingpong_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_pingpong_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .pkt_done(pkt_done), .xfer_done(xfer_done), .rd_en(rd_en),
    .rd_addr(rd_addr), .wr_buf(wr_buf), .src_sel(src_sel),
    .xfer_cnt(xfer_cnt), .rx_allow(rx_allow), .tmr_en(tmr_en),
    .underrun(underrun), .overflow(overflow), .smp_out(smp_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) pend = rd_en;

  always @(negedge clk) if (pend) begin
    if (exp_q.size() == 0) chk("R8 unexpected read", 1, 0);
    else chk("R8 smp_out", int'(smp_out), exp_q.pop_front());
  end

  task automatic wr_pkt(int n, int base, bit done_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_data = DW'(base + i);
      pkt_done = done_last && (i == n - 1);
    end
    @(negedge clk);
    wr_valid = 0; pkt_done = 0;
    if (!done_last) begin
      pkt_done = 1;
      @(negedge clk);
      pkt_done = 0;
    end
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  task automatic rd(int addr, int exp);
    @(negedge clk); rd_en = 1; rd_addr = AW'(addr); exp_q.push_back(exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 wr_buf", wr_buf, 0);   chk("R1 src_sel", src_sel, 0);
    chk("R1 rx_allow", rx_allow, 1); chk("R1 tmr_en", tmr_en, 0);
    chk("R1 xfer_cnt", xfer_cnt, 0); chk("R1 underrun", underrun, 0);
    chk("R1 overflow", overflow, 0);

    pulse_xfer();
    chk("R11 wr_buf", wr_buf, 0); chk("R11 tmr_en", tmr_en, 0);
    chk("R11 xfer_cnt", xfer_cnt, 0);

    wr_pkt(5, 'h100, 0);
    chk("R2 wr_buf", wr_buf, 1); chk("R2 rx_allow", rx_allow, 1);
    chk("R2 tmr_en", tmr_en, 0);

    wr_pkt(7, 'h200, 1);
    chk("R3 wr_buf", wr_buf, 0); chk("R3 src_sel", src_sel, 0);
    chk("R3 xfer_cnt", xfer_cnt, 5); chk("R3 tmr_en", tmr_en, 1);
    chk("R3 rx_allow", rx_allow, 0);

    @(negedge clk); wr_valid = 1; wr_data = 'hBAD;
    @(negedge clk); wr_valid = 0;
    chk("R7 overflow", overflow, 1);
    @(negedge clk); pkt_done = 1;
    @(negedge clk); pkt_done = 0;
    chk("R9 wr_buf", wr_buf, 0); chk("R9 xfer_cnt", xfer_cnt, 5);
    chk("R9 src_sel", src_sel, 0); chk("R9 rx_allow", rx_allow, 0);

    for (int i = 0; i < 5; i++) rd(i, 'h100 + i);
    pulse_xfer();
    chk("R4 src_sel", src_sel, 1); chk("R10 xfer_cnt", xfer_cnt, 7);
    chk("R4 wr_buf", wr_buf, 0); chk("R4 rx_allow", rx_allow, 1);
    chk("R4 underrun", underrun, 0);
    for (int i = 0; i < 7; i++) rd(i, 'h200 + i);

    wr_pkt(3, 'h300, 0);
    chk("R5 rx_allow", rx_allow, 0); chk("R5 src_sel", src_sel, 1);
    chk("R5 xfer_cnt", xfer_cnt, 7); chk("R5 tmr_en", tmr_en, 1);

    pulse_xfer();
    chk("R4 src_sel", src_sel, 0); chk("R4 xfer_cnt", xfer_cnt, 3);
    chk("R4 wr_buf", wr_buf, 1);
    for (int i = 0; i < 3; i++) rd(i, 'h300 + i);

    pulse_xfer();
    chk("R6 underrun", underrun, 1); chk("R6 tmr_en", tmr_en, 0);
    repeat (3) @(negedge clk);
    chk("R6 smp_out held", smp_out, 'h302);

    wr_pkt(4, 'h400, 1);
    chk("R6 underrun clear", underrun, 0); chk("R6 tmr_en", tmr_en, 1);
    chk("R6 src_sel", src_sel, 1); chk("R6 wr_buf", wr_buf, 0);
    chk("R6 xfer_cnt", xfer_cnt, 4); chk("R6 rx_allow", rx_allow, 1);
    for (int i = 0; i < 4; i++) rd(i, 'h400 + i);

    wr_pkt(DEPTH + 2, 'h500, 0);
    chk("R5 rx_allow", rx_allow, 0);
    pulse_xfer();
    chk("R10 src_sel", src_sel, 0); chk("R10 xfer_cnt", xfer_cnt, DEPTH);
    rd(0, 'h500);
    rd(DEPTH - 1, 'h500 + DEPTH - 1);

    repeat (2) @(negedge clk);
    chk("R8 all reads seen", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule